// File: doc/BRIEF.md
# Five-Channel Double-Buffered PWM Timer

This block holds five independent down-counting timer channels behind a small word-wide register port. Software writes a period value and a threshold value for each channel into staging buffers. A single shared control word then starts each channel, forces a load from its staging buffers, selects output polarity and chooses whether the channel re-arms itself at the end of every period. Each channel advances by one step on each pulse of its own tick-enable input, so the rate is set outside the block.

When a channel's counter is at or below its live threshold, that channel's pre-polarity level is high. Otherwise the level is low. The first four channels drive an output pin. The fifth channel counts in the same way but has no pin, so it is useful only as a time base. Because the staging buffers are separate from the live counter and the live threshold, software can prepare the next period while the current one runs. The new values take effect at the next reload.

Top module: `pwmt_top`

## Requirements
- R1: After synchronous reset, every pwm_out bit is low and every register reads zero. A channel's output stays low until that channel first receives a manual load, provided its invert bit stays clear.
- R2: The control word is at byte offset 0x08. Channel 0 owns bits 3:0, and channel n (n≥1) owns the four bits starting at bit 4(n+1). Within a group, +0 is start, +1 is manual load, +2 is invert and +3 is auto-reload. Channel 4 is the exception: its auto-reload is +2 (bit 22) and it has no invert bit. Bits 7:4, 23 and 31:24 read zero, so writing all ones reads back 0x007FFF0F.
- R3: The period buffer of channel n is at offset 0x0C+12n and its threshold buffer is at 0x10+12n. Each buffer keeps the low CNT_W bits and reads back zero above them. Read data appears on bus_rdata one clock after bus_addr. An unmapped offset reads zero.
- R4: In every clock where a channel's manual-load bit is set, its counter loads the period buffer and its live threshold loads the threshold buffer. No tick is needed. Otherwise the counter moves only on a tick while start is set. With start clear, the counter and the output hold.
- R5: The counter decrements by one on each tick, so a period value N gives a period of N+1 ticks. The pre-polarity level is low while the counter is above the live threshold and high while it is at or below it. A threshold C≤N therefore gives C+1 high ticks per period. pwm_out is registered and follows the counter one clock later.
- R6: On a tick with the counter at zero, an auto-reload channel reloads both the counter and the live threshold from its buffers. With auto-reload clear, the counter stays at zero and the output keeps its level.
- R7: A threshold of all ones (0xFFFF with CNT_W=16) is never passed, so the level stays high for the whole period. This gives 100% duty.
- R8: A set invert bit inverts that channel's pwm_out bit. Channel 4 drives no pin.
- R9: Writing a buffer does not change the running period. The value is used at the next load. A buffer write in the same clock as a reload is not seen by that reload.
- R10: tick_en[n] advances only channel n. The other channels hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for bus_addr/bus_wdata |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous clock's bus_addr |
| tick_en | input | 5 | Per-channel count enable, one bit per channel |
| pwm_out | output | 4 | Registered outputs of channels 0 to 3 |

## Verification
Two functions can fall in the same clock: a channel's reload at the end of its period, and a software write to that channel's period buffer. The bench runs a channel down to zero. It then issues the tick and the buffer write on the same edge. The output pattern over the following periods must show that the old period length was reloaded once before the new one appears. A threshold write in the middle of a period is judged in the same way: the high pulse must stay where the old threshold places it until the next reload.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  localparam int unsigned CTRL_OFS  = 8;
  localparam int unsigned CBUF_OFS  = 12;
  localparam int unsigned PBUF_OFS  = 16;
  localparam int unsigned CH_STRIDE = 12;

  // lowest bit of a channel's group; one empty group follows channel 0
  function automatic int unsigned grp_lsb(input int unsigned ch);
    return (ch == 0) ? 0 : 4 * (ch + 1);
  endfunction

  function automatic int unsigned pos_start(input int unsigned ch);
    return grp_lsb(ch);
  endfunction

  function automatic int unsigned pos_manual(input int unsigned ch);
    return grp_lsb(ch) + 1;
  endfunction

  function automatic int unsigned pos_invert(input int unsigned ch);
    return grp_lsb(ch) + 2;
  endfunction

  // the last channel has no invert bit; its reload bit takes that place
  function automatic int unsigned pos_reload(input int unsigned ch, input int unsigned nch);
    return (ch == nch - 1) ? grp_lsb(ch) + 2 : grp_lsb(ch) + 3;
  endfunction

  function automatic logic [31:0] ctrl_mask(input int unsigned nch);
    logic [31:0] m;
    m = '0;
    for (int unsigned c = 0; c < nch; c++) begin
      m[5'(pos_start(c))]       = 1'b1;
      m[5'(pos_manual(c))]      = 1'b1;
      m[5'(pos_reload(c, nch))] = 1'b1;
      if (c != nch - 1) m[5'(pos_invert(c))] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [DATA_W-1:0]              ctrl_q,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cbuf,
  output logic [NUM_CH-1:0][CNT_W-1:0]   pbuf
);

  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(ctrl_mask(NUM_CH));
  localparam logic [ADDR_W-1:0] CTRL_A    = ADDR_W'(CTRL_OFS);

  logic [DATA_W-1:0] rd_d;

  // buffers stay in flops: every channel reads its pair in every clock
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cbuf   <= '0;
      pbuf   <= '0;
    end else if (bus_wr) begin
      if (bus_addr == CTRL_A) ctrl_q <= bus_wdata & CTRL_MASK;
      for (int n = 0; n < NUM_CH; n++) begin
        if (bus_addr == ADDR_W'(CBUF_OFS + CH_STRIDE * n)) cbuf[n] <= bus_wdata[CNT_W-1:0];
        if (bus_addr == ADDR_W'(PBUF_OFS + CH_STRIDE * n)) pbuf[n] <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_d = '0;
    if (bus_addr == CTRL_A) rd_d = ctrl_q;
    for (int n = 0; n < NUM_CH; n++) begin
      if (bus_addr == ADDR_W'(CBUF_OFS + CH_STRIDE * n)) rd_d = DATA_W'(cbuf[n]);
      if (bus_addr == ADDR_W'(PBUF_OFS + CH_STRIDE * n)) rd_d = DATA_W'(pbuf[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  // R2
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == CTRL_A) |=> ((bus_rdata & ~CTRL_MASK) == '0));

endmodule

// File: rtl/pwmt_chan.sv
module pwmt_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic             manual,
  input  logic             auto_rl,
  input  logic             invert,
  input  logic [CNT_W-1:0] cnt_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic             pwm_o
);

  localparam logic [CNT_W-1:0] ONES = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  logic             armed;
  logic             step;
  logic             level;

  assign step  = start & tick;
  assign level = armed & (cnt <= cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      cmp   <= '0;
      armed <= 1'b0;
    end else if (manual) begin
      cnt   <= cnt_buf;
      cmp   <= cmp_buf;
      armed <= 1'b1;
    end else if (step) begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (auto_rl) begin
        cnt <= cnt_buf;
        cmp <= cmp_buf;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= level ^ invert;
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!manual && !step) |=> ($stable(cnt) && $stable(cmp)));

  // R4
  load_chk: assert property (@(posedge clk) disable iff (rst)
    manual |=> ((cnt == $past(cnt_buf)) && (cmp == $past(cmp_buf))));

  // R5
  dec_chk: assert property (@(posedge clk) disable iff (rst)
    (!manual && step && (cnt != '0)) |=> (cnt == $past(cnt) - 1'b1));

  // R6
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    (!manual && step && (cnt == '0) && !auto_rl) |=> (cnt == '0));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (!manual && step && (cnt == '0) && auto_rl) |=> (cnt == $past(cnt_buf)));

  // R7
  full_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && (cmp == ONES) && !invert) |=> pwm_o);

endmodule

// File: rtl/pwmt_top.sv
module pwmt_top
  import pwmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] tick_en,
  output logic [NUM_CH-2:0] pwm_out
);

  localparam int unsigned LAST     = NUM_CH - 1;
  localparam int unsigned LAST_MAN = pos_manual(LAST);

  logic [DATA_W-1:0]            ctrl_q;
  logic [NUM_CH-1:0][CNT_W-1:0] cbuf;
  logic [NUM_CH-1:0][CNT_W-1:0] pbuf;
  logic [NUM_CH-1:0]            ch_o;

  pwmt_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctrl_q(ctrl_q), .cbuf(cbuf), .pbuf(pbuf)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int unsigned P_ST = pos_start(n);
    localparam int unsigned P_MU = pos_manual(n);
    localparam int unsigned P_AR = pos_reload(n, NUM_CH);
    logic inv;
    if (n == LAST) begin : g_noinv
      assign inv = 1'b0;
    end else begin : g_inv
      assign inv = ctrl_q[pos_invert(n)];
    end
    pwmt_chan #(.CNT_W(CNT_W)) chan_i (
      .clk(clk), .rst(rst), .tick(tick_en[n]),
      .start(ctrl_q[P_ST]), .manual(ctrl_q[P_MU]), .auto_rl(ctrl_q[P_AR]),
      .invert(inv), .cnt_buf(cbuf[n]), .cmp_buf(pbuf[n]), .pwm_o(ch_o[n])
    );
  end

  assign pwm_out = ch_o[NUM_CH-2:0];

  // R7
  last_full_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_q[LAST_MAN], 2) && ($past(pbuf[LAST], 2) == '1)) |-> ch_o[LAST]);

endmodule

// File: tb/pwmt_top_tb_top.sv
`timescale 1ns/1ps
module pwmt_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  tick_en = '0;
  logic [3:0]  pwm_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // channel model
  int mcnt, mcmp, mbc, mbp;
  bit mst, mauto, minv;

  always #10 clk = ~clk;

  pwmt_top dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .pwm_out(pwm_out)
  );

  function automatic logic [7:0] cb_a(int ch); return 8'(12 + 12 * ch); endfunction
  function automatic logic [7:0] pb_a(int ch); return 8'(16 + 12 * ch); endfunction

  function automatic logic [31:0] ctl(int ch, bit st, bit mu, bit inv, bit ar);
    logic [31:0] r;
    int b;
    r = '0;
    b = (ch == 0) ? 0 : 4 * (ch + 1);
    r[b]   = st;
    r[b+1] = mu;
    if (ch == 4) r[b+2] = ar;
    else begin
      r[b+2] = inv;
      r[b+3] = ar;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic model_tick();
    if (mst) begin
      if (mcnt != 0) mcnt--;
      else if (mauto) begin
        mcnt = mbc;
        mcmp = mbp;
      end
    end
  endtask

  task automatic tick(input logic [4:0] m);
    tick_en = m;
    @(negedge clk);
    tick_en = '0;
    @(negedge clk);
  endtask

  task automatic tick_wr(input logic [4:0] m, input logic [7:0] a, input logic [31:0] d);
    tick_en = m; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    tick_en = '0; bus_wr = 1'b0;
    @(negedge clk);
  endtask

  function automatic bit exp_out();
    return bit'(mcnt <= mcmp) ^ minv;
  endfunction

  task automatic chk_ch(input string tag, input int ch);
    chk(tag, {31'b0, pwm_out[ch]}, {31'b0, exp_out()});
  endtask

  task automatic load(input int ch, input int n, input int c, input bit st, input bit ar, input bit inv);
    mbc = n; mbp = c;
    wr(cb_a(ch), 32'(n));
    wr(pb_a(ch), 32'(c));
    wr(8'h08, ctl(ch, st, 1'b1, inv, ar));
    wr(8'h08, ctl(ch, st, 1'b0, inv, ar));
    mcnt = n; mcmp = c; mst = st; mauto = ar; minv = inv;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pwm_out", {28'b0, pwm_out}, 32'h0);
    rd(8'h08, d); chk("R1 ctrl", d, 32'h0);
    rd(cb_a(0), d); chk("R1 cbuf0", d, 32'h0);
    rd(pb_a(3), d); chk("R1 pbuf3", d, 32'h0);

    // R2 control layout
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R2 all ones", d, 32'h007F_FF0F);
    wr(8'h08, ctl(4, 1'b0, 1'b0, 1'b0, 1'b1));
    rd(8'h08, d); chk("R2 ch4 reload bit22", d, 32'h0040_0000);
    wr(8'h08, 32'h0);

    // R3 buffers
    for (int n = 0; n < 5; n++) begin
      wr(cb_a(n), 32'hBEEF_0000 | 32'(n * 16 + 3));
      wr(pb_a(n), 32'h5A5A_0000 | 32'(256 + n));
    end
    for (int n = 0; n < 5; n++) begin
      rd(cb_a(n), d); chk("R3 period buf", d, 32'(n * 16 + 3));
      rd(pb_a(n), d); chk("R3 threshold buf", d, 32'(256 + n));
    end
    rd(8'h04, d); chk("R3 unmapped", d, 32'h0);

    // R5 R7 R8 sweep
    for (int ch = 0; ch < 4; ch++) begin
      for (int ni = 0; ni < 3; ni++) begin
        int n;
        n = (ni == 0) ? 1 : (ni == 1) ? 2 : 4;
        for (int ci = 0; ci <= n + 1; ci++) begin
          int c;
          string tag;
          c = (ci == n + 1) ? 32'hFFFF : ci;
          tag = (c == 32'hFFFF) ? "R7 full duty" : (ch % 2 == 1) ? "R8 inverted R5" : "R5 duty";
          load(ch, n, c, 1'b1, 1'b1, bit'(ch % 2));
          chk_ch(tag, ch);
          for (int t = 0; t < 2 * (n + 1) + 1; t++) begin
            tick(5'b1 << ch);
            model_tick();
            chk_ch(tag, ch);
          end
        end
      end
    end

    // R4 start clear freezes
    load(0, 5, 2, 1'b0, 1'b1, 1'b0);
    chk_ch("R4 frozen", 0);
    for (int t = 0; t < 4; t++) begin
      tick(5'b00001); model_tick(); chk_ch("R4 frozen", 0);
    end
    wr(8'h08, ctl(0, 1'b1, 1'b0, 1'b0, 1'b1)); mst = 1'b1;
    for (int t = 0; t < 4; t++) begin
      tick(5'b00001); model_tick(); chk_ch("R4 running", 0);
    end

    // R6 no auto-reload: stop at zero
    load(1, 2, 0, 1'b1, 1'b0, 1'b0);
    for (int t = 0; t < 6; t++) begin
      tick(5'b00010); model_tick(); chk_ch("R6 one shot", 1);
    end

    // R9 double buffering and write colliding with reload
    load(2, 3, 1, 1'b1, 1'b1, 1'b0);
    tick(5'b00100); model_tick(); chk_ch("R9 mid period", 2);
    wr(pb_a(2), 32'h0); mbp = 0;
    while (mcnt != 0) begin
      tick(5'b00100); model_tick(); chk_ch("R9 old threshold kept", 2);
    end
    tick_wr(5'b00100, cb_a(2), 32'h1);
    model_tick(); mbc = 1;
    chk_ch("R9 collide reload", 2);
    for (int t = 0; t < 9; t++) begin
      tick(5'b00100); model_tick(); chk_ch("R9 after collide", 2);
    end

    // R10 channel independence (period 3, threshold 1)
    wr(cb_a(0), 32'd3); wr(pb_a(0), 32'd1);
    wr(cb_a(1), 32'd3); wr(pb_a(1), 32'd1);
    wr(8'h08, ctl(0, 1'b1, 1'b1, 1'b0, 1'b1) | ctl(1, 1'b1, 1'b1, 1'b0, 1'b1));
    wr(8'h08, ctl(0, 1'b1, 1'b0, 1'b0, 1'b1) | ctl(1, 1'b1, 1'b0, 1'b0, 1'b1));
    @(negedge clk);
    tick(5'b00010); tick(5'b00010);
    chk("R10 ch1 at 1 high", {31'b0, pwm_out[1]}, 32'h1);
    chk("R10 ch0 held at 3 low", {31'b0, pwm_out[0]}, 32'h0);
    tick(5'b00001); tick(5'b00001);
    chk("R10 ch0 at 1 high", {31'b0, pwm_out[0]}, 32'h1);
    chk("R10 ch1 held high", {31'b0, pwm_out[1]}, 32'h1);
    tick(5'b00010); tick(5'b00010);
    chk("R10 ch1 reloaded low", {31'b0, pwm_out[1]}, 32'h0);
    chk("R10 ch0 still high", {31'b0, pwm_out[0]}, 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule